// File: doc/BRIEF.md
# Reloadable Down-Counter Timer with Prescaler

This block is a 16-bit down-counting timer. It advances from the system clock through a prescaler, and the prescaler divides by a selectable power of two. Software drives it through a small register port. The port carries a control word, a reload value and the live count, and the live count can be written to preset the counter. The control word selects the clock divider, turns counting on and off, chooses between continuous reload and one-shot operation, enables the interrupt and arms the external trigger. It also holds a sticky underflow flag.

An underflow is the wrap of the counter from 0x0000 past zero. In reload mode the counter then picks up the reload value and keeps running. In one-shot mode it lands on 0xFFFF and the run bit drops. An armed falling edge on the trigger input restarts the count from the reload value. The interrupt request follows the underflow flag, gated by the enable bit. During a read-modify-write access the flag reads back as 1, so software that writes that value back cannot clear the flag by accident.

Top module: `rdt_timer`

## Requirements
- R1: After reset the control register (address 0) reads 0x0000, the count register (address 2) reads 0xFFFF and `irq` is low.
- R2: While running, the count drops by one every D clock cycles. D is chosen by control bits 6:4: 000 gives 2, 001 gives 8, 010 gives 32, 101 gives 64 and 110 gives 128. The first decrement comes D cycles after the write that sets the run bit (control bit 0).
- R3: The divider codes 011, 100 and 111 produce no prescaler ticks, so the count holds while the run bit is 1.
- R4: An underflow is a tick taken while the count is 0x0000. With reload enable (control bit 3) at 1, the count becomes the reload register value (address 1) and the run bit stays 1.
- R5: With reload enable at 0, an underflow leaves the count at 0xFFFF and clears the run bit, and counting then stays stopped.
- R6: An underflow sets the flag (control bit 1). A control write with bit 1 at 0 clears the flag, and a write with bit 1 at 1 leaves it unchanged. When an underflow and a clearing write fall in the same cycle, the flag ends set.
- R7: A read of address 0 with `rmw` high returns bit 1 as 1 whatever the flag holds.
- R8: `irq` is high exactly when the flag is 1 and the interrupt enable (control bit 2) is 1.
- R9: With the run bit at 0, both the count and the prescaler phase hold. Counting resumes from the held phase.
- R10: With trigger mode (control bit 7) and the run bit both at 1, a falling edge on `trig_in` passes a two-flop synchronizer and then loads the reload value and restarts the prescaler phase. The count shows the reload value after the third rising clock edge following the fall. With trigger mode at 0 the input is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 control, 1 reload, 2 count |
| wdata | input | 16 | Write data |
| rmw | input | 1 | Marks the current read as part of a read-modify-write |
| rdata | output | 16 | Read data for `addr` (combinational) |
| trig_in | input | 1 | External trigger, asynchronous |
| irq | output | 1 | Interrupt request |

## Verification
An underflow and a software clear of the flag can land in the same clock edge. The bench provokes this by running the counter in reload mode at divide-by-2 from a known phase. It times a flag-clearing control write so that it is captured on the exact edge of the second underflow. It then judges the result by the flag bit read back and by `irq`, both of which must stay high. A clearing write one cycle later must bring both low.

// File: rtl/rdt_pkg.sv
// Shared constants and helpers for the reloadable down-counter timer.
// Assumes a 2-bit register address and a 3-bit divider code.
package rdt_pkg;

    localparam logic [1:0] A_CTRL   = 2'd0;
    localparam logic [1:0] A_RELOAD = 2'd1;
    localparam logic [1:0] A_COUNT  = 2'd2;

    // Control word bit positions
    localparam int B_RUN   = 0;
    localparam int B_FLAG  = 1;
    localparam int B_IE    = 2;
    localparam int B_RELD  = 3;
    localparam int B_SRC   = 4;
    localparam int B_TMODE = 7;

    // Maps a divider code to log2 of the divide ratio; 0 marks a forbidden code.
    function automatic logic [2:0] src_shift(input logic [2:0] code);
        case (code)
            3'b000:  src_shift = 3'd1;
            3'b001:  src_shift = 3'd3;
            3'b010:  src_shift = 3'd5;
            3'b101:  src_shift = 3'd6;
            3'b110:  src_shift = 3'd7;
            default: src_shift = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/rdt_prescaler.sv
// Power-of-two prescaler. Emits a one-cycle tick every 2^k cycles while
// enabled; a forbidden code yields no ticks. Phase holds when disabled and
// returns to zero on restart. Assumes PRE_W >= 7 to fit the largest ratio.
module rdt_prescaler #(
    parameter int PRE_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [2:0] src,
    output logic       tick
);
    logic [2:0]       shift;
    logic             valid;
    logic [PRE_W-1:0] last;
    logic [PRE_W-1:0] phase_q;

    // Decode the divider code into a terminal phase value.
    always_comb begin
        shift = rdt_pkg::src_shift(src);
        valid = (shift != 3'd0);
        last  = PRE_W'((32'd1 << shift) - 32'd1);
    end

    assign tick = run && valid && (phase_q >= last);

    // Advance the phase while running with a legal code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart) begin
            phase_q <= '0;
        end else if (run && valid) begin
            if (phase_q >= last) phase_q <= '0;
            else                 phase_q <= phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/rdt_edge_det.sv
// Synchronizes an asynchronous input through STAGES flops and flags a
// falling edge for one cycle. Assumes STAGES >= 2.
module rdt_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Shift the input through the synchronizer and keep the prior level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign fall = last_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/rdt_counter.sv
// Down counter with software preset, trigger restart and underflow handling.
// Priority: software preset, then restart, then tick. Underflow is reported
// only when a tick is taken at zero.
module rdt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_sw,
    input  logic [CNT_W-1:0] load_val,
    input  logic             restart,
    input  logic [CNT_W-1:0] reload,
    input  logic             tick,
    input  logic             reld,
    output logic [CNT_W-1:0] count,
    output logic             uf
);
    logic at_zero;

    assign at_zero = (count == '0);
    assign uf      = tick && !load_sw && !restart && at_zero;

    // Update the count by preset, restart or prescaler tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '1;
        end else if (load_sw) begin
            count <= load_val;
        end else if (restart) begin
            count <= reload;
        end else if (tick) begin
            if (at_zero) count <= reld ? reload : '1;
            else         count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/rdt_timer.sv
// Top of the reloadable down-counter timer. Holds the control and reload
// registers, decodes the register port and gates the interrupt. Assumes a
// single clock domain; trig_in may be asynchronous.
module rdt_timer #(
    parameter int CNT_W       = 16,
    parameter int PRE_W       = 7,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic              rmw,
    output logic [CNT_W-1:0]  rdata,
    input  logic              trig_in,
    output logic              irq
);
    import rdt_pkg::*;

    localparam int CTRL_W = 8;

    logic             run, flag, ie, reld, tmode;
    logic [2:0]       src;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] count_q;
    logic             wr_ctrl, wr_rel, wr_cnt;
    logic             tick, uf, fall, restart;
    logic [CTRL_W-1:0] ctrl_rd;

    assign wr_ctrl = wr_en && (addr == ADDR_W'(A_CTRL));
    assign wr_rel  = wr_en && (addr == ADDR_W'(A_RELOAD));
    assign wr_cnt  = wr_en && (addr == ADDR_W'(A_COUNT));
    assign restart = fall && tmode && run;

    rdt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
        .src(src), .tick(tick)
    );

    rdt_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .din(trig_in), .fall(fall)
    );

    rdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load_sw(wr_cnt), .load_val(wdata),
        .restart(restart), .reload(reload_q), .tick(tick), .reld(reld),
        .count(count_q), .uf(uf)
    );

    // Control fields: written by software; run drops on a one-shot underflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run   <= 1'b0;
            ie    <= 1'b0;
            reld  <= 1'b0;
            tmode <= 1'b0;
            src   <= 3'b000;
        end else if (wr_ctrl) begin
            run   <= wdata[B_RUN];
            ie    <= wdata[B_IE];
            reld  <= wdata[B_RELD];
            tmode <= wdata[B_TMODE];
            src   <= wdata[B_SRC +: 3];
        end else if (uf && !reld) begin
            run   <= 1'b0;
        end
    end

    // Underflow flag: set wins over a software clear; writing 1 does nothing.
    always_ff @(posedge clk) begin
        if (!rst_n)                          flag <= 1'b0;
        else if (uf)                         flag <= 1'b1;
        else if (wr_ctrl && !wdata[B_FLAG])  flag <= 1'b0;
    end

    // Reload register write.
    always_ff @(posedge clk) begin
        if (!rst_n)      reload_q <= '0;
        else if (wr_rel) reload_q <= wdata;
    end

    // Assemble the control readback; the flag reads 1 in a read-modify-write.
    always_comb begin
        ctrl_rd          = '0;
        ctrl_rd[B_RUN]   = run;
        ctrl_rd[B_FLAG]  = flag | rmw;
        ctrl_rd[B_IE]    = ie;
        ctrl_rd[B_RELD]  = reld;
        ctrl_rd[B_SRC+:3] = src;
        ctrl_rd[B_TMODE] = tmode;
    end

    // Read data multiplexer.
    always_comb begin
        case (addr)
            ADDR_W'(A_CTRL):   rdata = CNT_W'(ctrl_rd);
            ADDR_W'(A_RELOAD): rdata = reload_q;
            ADDR_W'(A_COUNT):  rdata = count_q;
            default:           rdata = '0;
        endcase
    end

    assign irq = flag & ie;

endmodule

// File: rtl/rdt_timer_chk.sv
// Property checker for rdt_timer, attached by bind. Observes the register
// state and the internal tick/underflow strobes.
module rdt_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_cnt,
    input logic             wr_ctrl,
    input logic             tick,
    input logic             uf,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] reload,
    input logic             run,
    input logic             reld,
    input logic             ie,
    input logic             flag,
    input logic [2:0]       src,
    input logic             irq
);
    AST_FORBIDDEN_SRC_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (src == 3'b011 || src == 3'b100 || src == 3'b111) |-> !tick); // R3

    AST_RELOAD_ON_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (uf && reld) |=> (cnt == $past(reload))); // R4

    AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (uf && !reld && !wr_ctrl) |=> (!run && cnt == '1)); // R5

    AST_UNDERFLOW_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        uf |=> flag); // R6

    AST_FLAG_NEEDS_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !uf) |=> !flag); // R6

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |-> !irq); // R8

    AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_cnt) |=> $stable(cnt)); // R9

endmodule

bind rdt_timer rdt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_cnt(wr_cnt), .wr_ctrl(wr_ctrl),
    .tick(tick), .uf(uf), .cnt(count_q), .reload(reload_q), .run(run),
    .reld(reld), .ie(ie), .flag(flag), .src(src), .irq(irq)
);

// File: tb/rdt_timer_tb.sv
`timescale 1ns/1ps
module rdt_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'h0;
    logic        rmw = 1'b0;
    logic [15:0] rdata;
    logic        trig_in = 1'b1;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    rdt_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rmw(rmw), .rdata(rdata), .trig_in(trig_in), .irq(irq)
    );

    typedef struct packed {
        logic [2:0]  src;
        logic [15:0] start;
        logic [9:0]  waits;
        logic [15:0] expv;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{3'b000, 16'd10, 10'd6,   16'd7},
        '{3'b001, 16'd5,  10'd16,  16'd3},
        '{3'b001, 16'd5,  10'd15,  16'd4},
        '{3'b010, 16'd5,  10'd64,  16'd3},
        '{3'b101, 16'd5,  10'd128, 16'd3},
        '{3'b110, 16'd5,  10'd256, 16'd3},
        '{3'b011, 16'd5,  10'd50,  16'd5},
        '{3'b100, 16'd5,  10'd50,  16'd5},
        '{3'b111, 16'd5,  10'd50,  16'd5}
    };

    function automatic logic [15:0] cw(input logic run, input logic flg,
                                       input logic ie, input logic reld,
                                       input logic [2:0] src, input logic tm);
        return {8'h00, tm, src, reld, ie, flg, run};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; rmw = 1'b0; trig_in = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One write, captured on exactly one rising edge; returns at a falling edge.
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic m, output logic [15:0] v);
        addr = a; rmw = m;
        #1 v = rdata;
        rmw = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] v;

        // Divider table (R2, R3)
        for (int i = 0; i < NV; i++) begin
            do_reset();
            wr(2'd2, VECS[i].start);
            wr(2'd0, cw(1'b1, 1'b1, 1'b0, 1'b0, VECS[i].src, 1'b0));
            repeat (int'(VECS[i].waits)) @(negedge clk);
            rd(2'd2, 1'b0, v);
            if (VECS[i].src inside {3'b011, 3'b100, 3'b111}) check("R3 forbidden code", v, VECS[i].expv);
            else                                            check("R2 divide ratio", v, VECS[i].expv);
        end

        // R1 reset state
        do_reset();
        rd(2'd0, 1'b0, v); check("R1 ctrl reset", v, 16'h0000);
        rd(2'd2, 1'b0, v); check("R1 count reset", v, 16'hFFFF);
        check("R1 irq reset", {15'h0, irq}, 16'h0000);

        // R5 one-shot underflow, R8 irq, R6 write-1 / write-0, R7 rmw
        do_reset();
        wr(2'd2, 16'd1);
        wr(2'd0, cw(1'b1, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0));
        repeat (4) @(negedge clk);
        rd(2'd2, 1'b0, v); check("R5 count after one-shot", v, 16'hFFFF);
        rd(2'd0, 1'b0, v); check("R5 run cleared, flag set", v, 16'h0006);
        check("R8 irq with flag and enable", {15'h0, irq}, 16'h0001);
        repeat (6) @(negedge clk);
        rd(2'd2, 1'b0, v); check("R5 stays stopped", v, 16'hFFFF);
        wr(2'd0, cw(1'b0, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0));
        rd(2'd0, 1'b0, v); check("R6 writing 1 keeps flag", v, 16'h0006);
        wr(2'd0, cw(1'b0, 1'b0, 1'b1, 1'b0, 3'b000, 1'b0));
        rd(2'd0, 1'b0, v); check("R6 writing 0 clears flag", v, 16'h0004);
        check("R8 irq drops with flag", {15'h0, irq}, 16'h0000);
        rd(2'd0, 1'b1, v); check("R7 rmw read shows flag", v, 16'h0006);

        // R8 enable off: flag set yet no request
        do_reset();
        wr(2'd2, 16'd0);
        wr(2'd0, cw(1'b1, 1'b1, 1'b0, 1'b0, 3'b000, 1'b0));
        repeat (2) @(negedge clk);
        rd(2'd0, 1'b0, v); check("R8 flag set with enable off", v, 16'h0002);
        check("R8 irq masked", {15'h0, irq}, 16'h0000);

        // R4 reload mode
        do_reset();
        wr(2'd1, 16'd5);
        wr(2'd2, 16'd0);
        wr(2'd0, cw(1'b1, 1'b1, 1'b1, 1'b1, 3'b000, 1'b0));
        repeat (2) @(negedge clk);
        rd(2'd2, 1'b0, v); check("R4 reload on underflow", v, 16'd5);
        rd(2'd0, 1'b0, v); check("R4 keeps running", v, 16'h000F);
        repeat (2) @(negedge clk);
        rd(2'd2, 1'b0, v); check("R4 continues counting", v, 16'd4);

        // R9 hold of count and prescaler phase
        do_reset();
        wr(2'd2, 16'd9);
        repeat (10) @(negedge clk);
        rd(2'd2, 1'b0, v); check("R9 count holds while stopped", v, 16'd9);
        wr(2'd0, cw(1'b1, 1'b1, 1'b0, 1'b0, 3'b000, 1'b0));
        wr(2'd0, cw(1'b0, 1'b1, 1'b0, 1'b0, 3'b000, 1'b0));
        repeat (5) @(negedge clk);
        wr(2'd0, cw(1'b1, 1'b1, 1'b0, 1'b0, 3'b000, 1'b0));
        @(negedge clk);
        rd(2'd2, 1'b0, v); check("R9 prescaler phase held", v, 16'd8);

        // R10 trigger falling edge
        do_reset();
        wr(2'd1, 16'd42);
        wr(2'd2, 16'd100);
        wr(2'd0, cw(1'b1, 1'b1, 1'b0, 1'b0, 3'b011, 1'b1));
        repeat (3) @(negedge clk);
        trig_in = 1'b0;
        repeat (2) @(negedge clk);
        rd(2'd2, 1'b0, v); check("R10 no load before sync delay", v, 16'd100);
        @(negedge clk);
        rd(2'd2, 1'b0, v); check("R10 trigger loads reload", v, 16'd42);

        do_reset();
        wr(2'd1, 16'd42);
        wr(2'd2, 16'd100);
        wr(2'd0, cw(1'b1, 1'b1, 1'b0, 1'b0, 3'b011, 1'b0));
        repeat (3) @(negedge clk);
        trig_in = 1'b0;
        repeat (5) @(negedge clk);
        rd(2'd2, 1'b0, v); check("R10 trigger ignored in mode 0", v, 16'd100);

        // R6 clear and underflow in the same cycle
        do_reset();
        wr(2'd1, 16'd7);
        wr(2'd2, 16'd0);
        wr(2'd0, cw(1'b1, 1'b1, 1'b1, 1'b1, 3'b000, 1'b0));
        repeat (17) @(negedge clk);
        wr(2'd0, cw(1'b1, 1'b0, 1'b1, 1'b1, 3'b000, 1'b0));
        rd(2'd2, 1'b0, v); check("R4 second underflow reloads", v, 16'd7);
        rd(2'd0, 1'b0, v); check("R6 set wins over clear", v, 16'h000F);
        check("R8 irq stays with set flag", {15'h0, irq}, 16'h0001);
        wr(2'd0, cw(1'b1, 1'b0, 1'b1, 1'b1, 3'b000, 1'b0));
        rd(2'd0, 1'b0, v); check("R6 later clear works", v, 16'h000D);

        summary();
        $finish;
    end
endmodule